// File: doc/BRIEF.md
# Over-Temperature Alert Controller

This block turns a stream of signed temperature samples into a single alert pin level. Each accepted sample is compared with a programmable trip limit and a hysteresis limit. A consecutive-fault qualifier filters out single noisy readings before a trip counts. Two latching behaviours are offered. In comparator mode the alert follows the temperature with hysteresis. In interrupt mode the alert latches on a qualified trip, clears on any register read, and waits for a fresh trip before it can fire again.

A shutdown flag freezes evaluation without disturbing the stored alert state or the fault count. A polarity input chooses whether the asserted pin level is high or low. The serial bus, the alert-response protocol and the temperature conversion are handled elsewhere. This block sees them only as a sample strobe and a read strobe.

Top module: `temp_alert_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the alert is inactive and the fault count is zero. The pin then sits at the inactive level given by `pol_i`.
- R2: With `mode_i`=0 (comparator), a qualified sample at or above the trip limit asserts the alert. The pin changes on the clock edge that accepts the sample.
- R3: In comparator mode the alert clears only on an accepted sample strictly below the hysteresis limit. Samples from the hysteresis limit up to just under the trip limit leave it set.
- R4: While `shdn_i`=1, no sample is evaluated. Both the fault count and the comparator-mode alert state hold their values.
- R5: `fq_sel_i` selects the number of consecutive trip samples needed: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 6. Any accepted sample below the trip limit resets the count to zero.
- R6: With `mode_i`=1 (interrupt), the alert asserts on the sample that first brings the consecutive count up to the selected number.
- R7: In interrupt mode a `reg_rd_i` pulse clears the alert. A qualification in the same cycle wins over the read. In comparator mode `reg_rd_i` has no effect.
- R8: After an interrupt-mode clear, further trip samples do not reassert the alert. A new trip is needed, which means at least one sample below the trip limit followed by a fresh qualification.
- R9: With `pol_i`=1 an asserted alert drives the pin high. With `pol_i`=0 it drives the pin low.
- R10: Temperature and limits are compared as 16-bit signed two's-complement values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | A new temperature sample is present |
| temp_i | input | 16 | Signed temperature sample |
| trip_lim_i | input | 16 | Signed trip limit |
| hyst_lim_i | input | 16 | Signed hysteresis limit |
| mode_i | input | 1 | 0 selects comparator, 1 selects interrupt |
| pol_i | input | 1 | 1 makes the pin active high, 0 active low |
| fq_sel_i | input | 2 | Consecutive-fault count select |
| shdn_i | input | 1 | Shutdown: samples are ignored |
| reg_rd_i | input | 1 | Pulse for any register read |
| alert_pin_o | output | 1 | Alert pin level |

## Verification
The alert state and the fault counter are each one register stage. Every result of an accepted sample or a read pulse therefore shows at the pin right after the rising edge that takes that input. Polarity is combinational and shows as soon as `pol_i` changes. The bench drives each stimulus on a falling edge and samples the pin on the next falling edge, so each check lands one edge after its cause. Multi-sample scenarios check the pin after every sample, which catches a count that is one too high or one too low.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;
  parameter int unsigned TEMP_W = 16;
  parameter int unsigned FQ_W   = 2;
  parameter int unsigned CNT_W  = 3;

  typedef enum logic {
    MODE_CMP = 1'b0,
    MODE_INT = 1'b1
  } alert_mode_e;

  function automatic logic [CNT_W-1:0] fault_need(input logic [FQ_W-1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(2);
      2'd2:    return CNT_W'(4);
      default: return CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/ta_fault_qual.sv
module ta_fault_qual
  import temp_alert_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     eval_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic signed [TEMP_W-1:0] trip_i,
  input  logic [FQ_W-1:0]          fq_sel_i,
  output logic                     trip_lvl_o,
  output logic                     trip_new_o
);
  localparam int unsigned CW1 = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, need;
  logic [CW1-1:0]   cnt_p1;
  logic             over;

  always_comb begin
    need   = fault_need(fq_sel_i);
    over   = temp_i >= trip_i;
    cnt_p1 = {1'b0, cnt_q} + CW1'(1);
    // saturate at the required count so a long trip keeps a stable level
    cnt_d  = cnt_q;
    if (eval_i) cnt_d = !over ? '0 : (cnt_q >= need) ? cnt_q : cnt_p1[CNT_W-1:0];
    trip_lvl_o = eval_i && over && (cnt_p1 >= {1'b0, need});
    trip_new_o = trip_lvl_o && (cnt_q < need);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(6)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(cnt_q)); // R4
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !over) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/ta_alert_latch.sv
module ta_alert_latch
  import temp_alert_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  alert_mode_e              mode_i,
  input  logic                     eval_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic signed [TEMP_W-1:0] hyst_i,
  input  logic                     trip_lvl_i,
  input  logic                     trip_new_i,
  input  logic                     rd_i,
  output logic                     alert_o
);
  logic alert_q, alert_d, below;

  always_comb begin
    below   = eval_i && (temp_i < hyst_i);
    alert_d = alert_q;
    unique case (mode_i)
      MODE_CMP: begin
        if (trip_lvl_i)  alert_d = 1'b1;
        else if (below)  alert_d = 1'b0;
      end
      MODE_INT: begin
        if (trip_new_i)  alert_d = 1'b1;
        else if (rd_i)   alert_d = 1'b0;
      end
      default: alert_d = alert_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_q <= 1'b0;
    else         alert_q <= alert_d;
  end

  assign alert_o = alert_q;

  AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_INT && rd_i && !trip_new_i) |=> !alert_q); // R7
  AST_INT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_INT && trip_new_i) |=> alert_q); // R6
  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CMP && !eval_i) |=> $stable(alert_q)); // R4
  AST_CMP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CMP && below && !trip_lvl_i) |=> !alert_q); // R3
endmodule

// File: rtl/ta_pin_drive.sv
module ta_pin_drive (
  input  logic alert_i,
  input  logic pol_i,
  output logic pin_o
);
  assign pin_o = pol_i ? alert_i : !alert_i;
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import temp_alert_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_vld_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic signed [TEMP_W-1:0] trip_lim_i,
  input  logic signed [TEMP_W-1:0] hyst_lim_i,
  input  logic                     mode_i,
  input  logic                     pol_i,
  input  logic [FQ_W-1:0]          fq_sel_i,
  input  logic                     shdn_i,
  input  logic                     reg_rd_i,
  output logic                     alert_pin_o
);
  logic        eval, trip_lvl, trip_new, alert;
  alert_mode_e mode;

  assign eval = sample_vld_i && !shdn_i;
  assign mode = alert_mode_e'(mode_i);

  ta_fault_qual u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eval_i     (eval),
    .temp_i     (temp_i),
    .trip_i     (trip_lim_i),
    .fq_sel_i   (fq_sel_i),
    .trip_lvl_o (trip_lvl),
    .trip_new_o (trip_new)
  );

  ta_alert_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .eval_i     (eval),
    .temp_i     (temp_i),
    .hyst_i     (hyst_lim_i),
    .trip_lvl_i (trip_lvl),
    .trip_new_i (trip_new),
    .rd_i       (reg_rd_i),
    .alert_o    (alert)
  );

  ta_pin_drive u_pin (
    .alert_i (alert),
    .pol_i   (pol_i),
    .pin_o   (alert_pin_o)
  );

  AST_SHDN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_i && !mode_i) |=> $stable(alert)); // R4
endmodule

// File: tb/temp_alert_ctrl_test.sv
module temp_alert_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vld = 1'b0;
  logic signed [15:0] temp = '0, trip = 16'sd100, hyst = 16'sd80;
  logic mode = 1'b0, pol = 1'b1, shdn = 1'b0, rd = 1'b0;
  logic [1:0] fq = 2'd0;
  logic pin;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  temp_alert_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_vld_i(vld), .temp_i(temp),
    .trip_lim_i(trip), .hyst_lim_i(hyst), .mode_i(mode), .pol_i(pol),
    .fq_sel_i(fq), .shdn_i(shdn), .reg_rd_i(rd), .alert_pin_o(pin)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (pin !== exp) begin
      errors++;
      $display("FAIL %s: pin=%b expected=%b at %0t", req, pin, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic smp(input logic signed [15:0] t);
    @(negedge clk); temp = t; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    pol = 1'b1; mode = 1'b0; fq = 2'd0;
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); chk("R1 in reset", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk); chk("R1 after reset", 1'b0);
    pol = 1'b0; #1 chk("R1/R9 inactive low-polarity", 1'b1);
    pol = 1'b1;
  endtask

  task automatic t_cmp();
    do_reset(); mode = 1'b0; fq = 2'd0; trip = 100; hyst = 80;
    smp(99);  chk("R2 below trip", 1'b0);
    smp(100); chk("R2 at trip", 1'b1);
    smp(90);  chk("R3 in band", 1'b1);
    smp(80);  chk("R3 equal hyst", 1'b1);
    smp(79);  chk("R3 below hyst", 1'b0);
    smp(101); chk("R2 above trip", 1'b1);
    rd_pulse(); chk("R7 read ignored in comparator", 1'b1);
  endtask

  task automatic t_shutdown();
    do_reset(); mode = 1'b0; fq = 2'd0;
    smp(120); chk("R4 setup", 1'b1);
    shdn = 1'b1;
    smp(0);   chk("R4 state held in shutdown", 1'b1);
    shdn = 1'b0;
    smp(0);   chk("R4 evaluates after shutdown", 1'b0);
    fq = 2'd2;
    smp(100); smp(100);
    shdn = 1'b1; smp(0); shdn = 1'b0;
    smp(100); chk("R4 count held (3 of 4)", 1'b0);
    smp(100); chk("R4 count held (4 of 4)", 1'b1);
  endtask

  task automatic t_fault_queue();
    do_reset(); mode = 1'b0; fq = 2'd3;
    for (int i = 0; i < 5; i++) smp(100);
    chk("R5 five of six", 1'b0);
    smp(100); chk("R5 six of six", 1'b1);
    smp(0);   chk("R5 clear", 1'b0);
    fq = 2'd1;
    smp(100); smp(50);
    smp(100); chk("R5 count restarted", 1'b0);
    smp(100); chk("R5 two of two", 1'b1);
  endtask

  task automatic t_interrupt();
    do_reset(); mode = 1'b1; fq = 2'd1; trip = 100; hyst = 80;
    smp(100); chk("R6 one of two", 1'b0);
    smp(100); chk("R6 qualified", 1'b1);
    smp(0);   chk("R6 latched below hyst", 1'b1);
    smp(100); smp(100);
    rd_pulse(); chk("R7 read clears", 1'b0);
    smp(100); chk("R8 no rearm while tripped", 1'b0);
    smp(50);  smp(100); chk("R8 one new sample", 1'b0);
    smp(100); chk("R8 new trip event", 1'b1);
  endtask

  task automatic t_signed();
    do_reset(); mode = 1'b0; fq = 2'd0; trip = -16'sd10; hyst = -16'sd20;
    smp(-16'sd15);    chk("R10 neg below trip", 1'b0);
    smp(-16'sd10);    chk("R10 neg at trip", 1'b1);
    smp(-16'sd20);    chk("R10 neg equal hyst", 1'b1);
    smp(-16'sd21);    chk("R10 neg below hyst", 1'b0);
    smp(16'sh8000);   chk("R10 most negative", 1'b0);
    smp(16'sh7FFF);   chk("R10 most positive", 1'b1);
    trip = 100; hyst = 80;
  endtask

  task automatic t_polarity();
    do_reset(); mode = 1'b0; fq = 2'd0; pol = 1'b0;
    smp(0);   chk("R9 low-active idle", 1'b1);
    smp(150); chk("R9 low-active asserted", 1'b0);
    pol = 1'b1; #1 chk("R9 high-active asserted", 1'b1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected end before timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_cmp();
    t_shutdown();
    t_fault_queue();
    t_interrupt();
    t_signed();
    t_polarity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule